// File: doc/BRIEF.md
# Multiplexed LCD Row Scan Sequencer

This block drives a dot-matrix panel with a 1:40 multiplex from the oscillator clock. It keeps a display memory of 40 rows by 101 columns. The memory is organised as five banks of 101 bytes, and a host write port fills it one byte at a time. The block selects one row at a time. At the start of each row it captures that row's bit from every column byte into a line register. It then drives the 101 column outputs from that line, shaped by a two-bit display mode and inverted on alternate frames by a polarity signal, so that the panel never sees a DC level.

A frame always lasts 3072 oscillator cycles. That is not a whole number of cycles per row, so the first 32 rows get 77 cycles each and the last 8 rows get 76 each. After reset is released, a two-cycle synchronous power-on sequence runs before scanning begins. A power-down input forces every row and column output high at once. While power-down is held, the scan position, the polarity and the memory are frozen, and host writes are still accepted.

Top module: `lcd_scan_seq`

## Requirements
- R1: While rst_n is low, and on the first two rising edges after it is sampled high, every row_sel_o and col_o bit is low and frame_pol_o is 0. In the cycle after the second such edge, row 0 alone is selected.
- R2: Outside power-down and once the power-on sequence is done, exactly one row_sel_o bit is high. Rows are selected in the order 0, 1, … 39, and then 0 again.
- R3: Rows 0 to 31 are each selected for 77 cycles and rows 32 to 39 for 76 cycles, so a full frame takes 3072 cycles.
- R4: frame_pol_o inverts only on the edge where row 39 hands over to row 0. Every column output equals the displayed pixel XOR frame_pol_o.
- R5: {mode_e_i, mode_d_i} selects the pixel: 00 gives blank (pixel 0), 01 all on (pixel 1), 10 normal (pixel equals the stored bit) and 11 inverse (pixel is the inverted stored bit). A change of mode takes effect on the current row without waiting for a clock edge.
- R6: For row r and column c, the stored bit is bit r%8 of the byte at bank r/8, column c. That bit drives col_o[c].
- R7: A row's data is captured when the row starts. A write to that row's byte while the row is selected leaves col_o unchanged until the row is scanned again.
- R8: A write with wr_bank_i ≥ 5 or wr_col_i ≥ 101 changes no stored byte.
- R9: While pd_i is high, all row_sel_o and col_o bits are high without waiting for a clock edge, and the scan position and frame_pol_o hold. When pd_i is released, the same row resumes for its remaining cycles. Writes made during power-down are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_i | input | 1 | Power-down: forces outputs high and freezes the scan |
| mode_e_i | input | 1 | Display mode, upper bit |
| mode_d_i | input | 1 | Display mode, lower bit |
| wr_en_i | input | 1 | Host byte write strobe |
| wr_bank_i | input | 3 | Bank (row group of eight) for the write |
| wr_col_i | input | 7 | Column for the write |
| wr_data_i | input | 8 | Byte written; bit k belongs to row 8*bank+k |
| row_sel_o | output | 40 | Row selects, active high |
| col_o | output | 101 | Column data after mode and polarity |
| frame_pol_o | output | 1 | Frame polarity |

## Verification
Several behaviours are checked on every cycle: the single active row, the one-step rotation of the select, the 77- and 76-cycle row lengths, the quiet outputs during the power-on sequence, the polarity flip only at the 39-to-0 hand-over, and the forced-high outputs with held polarity during power-down. Other behaviours need known memory contents and a reference model, so only the bench scenarios can show them. These are the bank and bit mapping of stored bytes onto columns, the four display modes, the deferred visibility of a write to the row being shown, the discarding of out-of-range writes, and the resumption of a row with its exact remaining cycles after power-down.

// File: rtl/lcd_scan_pkg.sv
// Package: shared types and helpers for the LCD row scan sequencer.
// Assumes the mode is encoded with the upper command bit as the MSB.
package lcd_scan_pkg;

    // Display mode, {upper bit, lower bit}
    typedef enum logic [1:0] {
        MODE_BLANK   = 2'b00,
        MODE_ALLON   = 2'b01,
        MODE_NORMAL  = 2'b10,
        MODE_INVERSE = 2'b11
    } disp_mode_e;

    // Pixel value for one stored bit under a display mode
    function automatic logic pixel_of(disp_mode_e mode, logic stored);
        case (mode)
            MODE_BLANK:  return 1'b0;
            MODE_ALLON:  return 1'b1;
            MODE_NORMAL: return stored;
            default:     return ~stored;
        endcase
    endfunction

endpackage

// File: rtl/scan_por.sv
// scan_por: synchronous power-on sequencer.
// Counts STAGES clock edges after reset is released, then holds done_o high.
// Assumes rst_n is already synchronous to clk.
module scan_por #(
    parameter int STAGES = 2,
    localparam int CNT_W = $clog2(STAGES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_o
);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STAGES);

    logic [CNT_W-1:0] cnt_q;

    assign done_o = (cnt_q == CNT_END);

    // Count the start-up edges, saturating at the end value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/scan_timer.sv
// scan_timer: row and in-row cycle counters for one frame of FRAME_CYCLES.
// The first FRAME_CYCLES % ROWS rows are one cycle longer than the rest,
// so the frame length is exact. Polarity flips when the last row ends.
// Everything holds while run_i is low.
module scan_timer #(
    parameter int ROWS         = 40,
    parameter int FRAME_CYCLES = 3072,
    localparam int ROW_W = $clog2(ROWS),
    localparam int BASE  = FRAME_CYCLES / ROWS,
    localparam int LONG  = FRAME_CYCLES % ROWS,
    localparam int CYC_W = $clog2(BASE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    output logic [ROW_W-1:0] row_o,
    output logic [ROW_W-1:0] next_row_o,
    output logic             advance_o,
    output logic             pol_o
);
    localparam logic [ROW_W-1:0] ROW_TOP    = ROW_W'(ROWS - 1);
    localparam logic [CYC_W-1:0] LAST_SHORT = CYC_W'(BASE - 1);

    logic [ROW_W-1:0] row_q;
    logic [CYC_W-1:0] cyc_q;
    logic             pol_q;
    logic             row_last;
    logic             cyc_last;

    assign row_last = (row_q == ROW_TOP);

    // Pick the end-of-row test: uniform rows, or a long group first
    generate
        if (LONG == 0) begin : g_uniform
            assign cyc_last = (cyc_q == LAST_SHORT);
        end else begin : g_split
            localparam logic [ROW_W-1:0] LONG_LIM  = ROW_W'(LONG);
            localparam logic [CYC_W-1:0] LAST_LONG = CYC_W'(BASE);
            assign cyc_last = (row_q < LONG_LIM) ? (cyc_q == LAST_LONG)
                                                 : (cyc_q == LAST_SHORT);
        end
    endgenerate

    assign advance_o  = run_i & cyc_last;
    assign next_row_o = row_last ? '0 : row_q + 1'b1;
    assign row_o      = row_q;
    assign pol_o      = pol_q;

    // Step the in-row counter, advance rows, flip polarity at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            cyc_q <= '0;
            pol_q <= 1'b0;
        end else if (run_i) begin
            if (cyc_last) begin
                cyc_q <= '0;
                row_q <= next_row_o;
                pol_q <= pol_q ^ row_last;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scan_ram.sv
// scan_ram: banked display memory with a row line register.
// Row r lives in bank r/BYTE_W at bit r%BYTE_W of every column byte.
// The memory itself has no reset; out-of-range writes are dropped.
// line_o is captured from rd_row_i whenever load_i is high.
module scan_ram #(
    parameter int ROWS   = 40,
    parameter int COLS   = 101,
    parameter int BYTE_W = 8,
    localparam int BANKS  = (ROWS + BYTE_W - 1) / BYTE_W,
    localparam int BANK_W = $clog2(BANKS),
    localparam int COL_W  = $clog2(COLS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int BIT_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [BANK_W-1:0] wr_bank_i,
    input  logic [COL_W-1:0]  wr_col_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              load_i,
    input  logic [ROW_W-1:0]  rd_row_i,
    output logic [COLS-1:0]   line_o
);
    localparam logic [BANK_W:0] BANK_LIM = (BANK_W + 1)'(BANKS);
    localparam logic [COL_W:0]  COL_LIM  = (COL_W + 1)'(COLS);

    logic [BYTE_W-1:0]      mem [BANKS][COLS];
    logic                   wr_ok;
    logic [ROW_W-BIT_W-1:0] rd_bank;
    logic [BIT_W-1:0]       rd_bit;
    logic [COLS-1:0]        fetch;
    logic [COLS-1:0]        line_q;

    assign wr_ok   = wr_en_i & ({1'b0, wr_bank_i} < BANK_LIM)
                             & ({1'b0, wr_col_i} < COL_LIM);
    assign rd_bank = rd_row_i[ROW_W-1:BIT_W];
    assign rd_bit  = rd_row_i[BIT_W-1:0];
    assign line_o  = line_q;

    // Host byte write, accepted in any state
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_bank_i][wr_col_i] <= wr_data_i;
        end
    end

    // Gather the addressed row's bit from every column byte
    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            fetch[c] = mem[rd_bank][c][rd_bit];
        end
    end

    // Capture the row line at the start of a row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (load_i) begin
            line_q <= fetch;
        end
    end
endmodule

// File: rtl/scan_drive.sv
// scan_drive: output stage for row selects and column data.
// Decodes the row index to a one-hot select and applies the mode and the
// polarity to each column. Power-down forces all outputs high; until
// start-up is done, all outputs are low.
module scan_drive
    import lcd_scan_pkg::*;
#(
    parameter int ROWS = 40,
    parameter int COLS = 101,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             por_done_i,
    input  logic             pd_i,
    input  disp_mode_e       mode_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [COLS-1:0]  line_i,
    input  logic             pol_i,
    output logic [ROWS-1:0]  row_sel_o,
    output logic [COLS-1:0]  col_o
);
    // One comparator per row select
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam logic [ROW_W-1:0] RIDX = ROW_W'(r);
        assign row_sel_o[r] = pd_i | (por_done_i & (row_i == RIDX));
    end

    // Mode and polarity per column
    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign col_o[c] = pd_i | (por_done_i & (pixel_of(mode_i, line_i[c]) ^ pol_i));
    end
endmodule

// File: rtl/lcd_scan_seq.sv
// lcd_scan_seq: top of the multiplexed LCD row scan sequencer.
// Runs from the oscillator clock. It holds for a short start-up sequence,
// then scans ROWS rows per FRAME_CYCLES. Each row's line is loaded from
// the banked memory when the row begins. Power-down freezes the scan.
// Assumes rst_n and pd_i are synchronous to clk.
module lcd_scan_seq
    import lcd_scan_pkg::*;
#(
    parameter int ROWS         = 40,
    parameter int COLS         = 101,
    parameter int FRAME_CYCLES = 3072,
    parameter int BYTE_W       = 8,
    parameter int POR_CYCLES   = 2,
    localparam int BANKS  = (ROWS + BYTE_W - 1) / BYTE_W,
    localparam int BANK_W = $clog2(BANKS),
    localparam int COL_W  = $clog2(COLS),
    localparam int ROW_W  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_i,
    input  logic              mode_e_i,
    input  logic              mode_d_i,
    input  logic              wr_en_i,
    input  logic [BANK_W-1:0] wr_bank_i,
    input  logic [COL_W-1:0]  wr_col_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [ROWS-1:0]   row_sel_o,
    output logic [COLS-1:0]   col_o,
    output logic              frame_pol_o
);
    logic             por_done;
    logic             run;
    logic [ROW_W-1:0] row;
    logic [ROW_W-1:0] next_row;
    logic             advance;
    logic             pol;
    logic             load;
    logic [ROW_W-1:0] fetch_row;
    logic [COLS-1:0]  line;
    disp_mode_e       mode;

    assign run         = por_done & ~pd_i;
    assign load        = ~por_done | advance;
    assign fetch_row   = advance ? next_row : row;
    assign mode        = disp_mode_e'({mode_e_i, mode_d_i});
    assign frame_pol_o = pol;

    scan_por #(
        .STAGES (POR_CYCLES)
    ) u_por (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_o (por_done)
    );

    scan_timer #(
        .ROWS         (ROWS),
        .FRAME_CYCLES (FRAME_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .row_o      (row),
        .next_row_o (next_row),
        .advance_o  (advance),
        .pol_o      (pol)
    );

    scan_ram #(
        .ROWS   (ROWS),
        .COLS   (COLS),
        .BYTE_W (BYTE_W)
    ) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_bank_i (wr_bank_i),
        .wr_col_i  (wr_col_i),
        .wr_data_i (wr_data_i),
        .load_i    (load),
        .rd_row_i  (fetch_row),
        .line_o    (line)
    );

    scan_drive #(
        .ROWS (ROWS),
        .COLS (COLS)
    ) u_drive (
        .por_done_i (por_done),
        .pd_i       (pd_i),
        .mode_i     (mode),
        .row_i      (row),
        .line_i     (line),
        .pol_i      (pol),
        .row_sel_o  (row_sel_o),
        .col_o      (col_o)
    );
endmodule

// File: rtl/lcd_scan_chk.sv
// lcd_scan_chk: cycle-level properties of the scan sequencer, bound to
// the top. It watches the outputs and the start-up done flag only.
module lcd_scan_chk #(
    parameter int ROWS         = 40,
    parameter int COLS         = 101,
    parameter int FRAME_CYCLES = 3072,
    localparam int BASE  = FRAME_CYCLES / ROWS,
    localparam int LONG  = FRAME_CYCLES % ROWS,
    localparam int SEG_W = $clog2(FRAME_CYCLES + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pd_i,
    input logic            por_done,
    input logic [ROWS-1:0] row_sel_o,
    input logic [COLS-1:0] col_o,
    input logic            frame_pol_o
);
    localparam logic [SEG_W-1:0] LEN_LONG  = SEG_W'(BASE + 1);
    localparam logic [SEG_W-1:0] LEN_SHORT = SEG_W'(BASE);

    logic [ROWS-1:0]  long_mask;
    logic [ROWS-1:0]  prev_sel;
    logic [SEG_W-1:0] seg_len;
    logic             prev_long;

    for (genvar r = 0; r < ROWS; r++) begin : g_mask
        assign long_mask[r] = (r < LONG);
    end
    assign prev_long = |(prev_sel & long_mask);

    // Measure how long each row stays selected, skipping power-down cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sel <= '0;
            seg_len  <= '0;
        end else if (por_done && !pd_i) begin
            if (row_sel_o == prev_sel) begin
                seg_len <= seg_len + 1'b1;
            end else begin
                if (prev_sel != '0) begin
                    a_r3_row_length: assert (seg_len == (prev_long ? LEN_LONG : LEN_SHORT))
                        else $error("R3 row length %0d", seg_len);
                end
                prev_sel <= row_sel_o;
                seg_len  <= SEG_W'(1);
            end
        end
    end

    a_r1_idle_during_por: assert property (@(posedge clk) disable iff (!rst_n)
        (!por_done && !pd_i) |-> (row_sel_o == '0 && col_o == '0 && !frame_pol_o));

    a_r2_single_row: assert property (@(posedge clk) disable iff (!rst_n)
        (por_done && !pd_i) |-> ($countones(row_sel_o) == 1));

    a_r2_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (por_done && !pd_i && $past(por_done) && !$past(pd_i)
         && row_sel_o != $past(row_sel_o))
        |-> (row_sel_o == {$past(row_sel_o[ROWS-2:0]), $past(row_sel_o[ROWS-1])}));

    a_r4_pol_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_pol_o) |-> (row_sel_o[0] && $past(row_sel_o[ROWS-1])));

    a_r9_pd_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
        pd_i |-> (&row_sel_o && &col_o));

    a_r9_pd_holds_pol: assert property (@(posedge clk) disable iff (!rst_n)
        pd_i |=> $stable(frame_pol_o));
endmodule

bind lcd_scan_seq lcd_scan_chk #(
    .ROWS         (ROWS),
    .COLS         (COLS),
    .FRAME_CYCLES (FRAME_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_i        (pd_i),
    .por_done    (por_done),
    .row_sel_o   (row_sel_o),
    .col_o       (col_o),
    .frame_pol_o (frame_pol_o)
);

// File: tb/lcd_scan_seq_bench.sv
`timescale 1ns/1ps
// Directed bench for lcd_scan_seq: one task per scenario.
// Inputs change and outputs are sampled at falling edges.
module lcd_scan_seq_bench;
    localparam int ROWS  = 40;
    localparam int COLS  = 101;
    localparam int FRAME = 3072;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pd = 1'b0;
    logic            me = 1'b1;
    logic            md = 1'b0;
    logic            we = 1'b0;
    logic [2:0]      wb = '0;
    logic [6:0]      wc = '0;
    logic [7:0]      wd = '0;
    logic [ROWS-1:0] rs;
    logic [COLS-1:0] co;
    logic            pol;

    int checks = 0;
    int failures = 0;
    logic [7:0] mdl [5][COLS];

    always #2 clk = ~clk;

    lcd_scan_seq u_lcd_scan_seq (
        .clk(clk), .rst_n(rst_n), .pd_i(pd), .mode_e_i(me), .mode_d_i(md),
        .wr_en_i(we), .wr_bank_i(wb), .wr_col_i(wc), .wr_data_i(wd),
        .row_sel_o(rs), .col_o(co), .frame_pol_o(pol)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int b, int c);
        return 8'((b * 53 + c * 29 + 7) ^ (c * 3));
    endfunction

    function automatic logic [ROWS-1:0] onehot(int r);
        logic [ROWS-1:0] v;
        v = '0;
        v[r] = 1'b1;
        return v;
    endfunction

    function automatic int row_idx(logic [ROWS-1:0] sel);
        for (int r = 0; r < ROWS; r++) begin
            if (sel[r]) return r;
        end
        return -1;
    endfunction

    // Expected columns for row r from the model, current mode and polarity p
    function automatic logic [COLS-1:0] exp_line(int r, logic p);
        logic [COLS-1:0] v;
        for (int c = 0; c < COLS; c++) begin
            logic b;
            logic px;
            b = mdl[r / 8][c][r % 8];
            case ({me, md})
                2'b00:   px = 1'b0;
                2'b01:   px = 1'b1;
                2'b10:   px = b;
                default: px = ~b;
            endcase
            v[c] = px ^ p;
        end
        return v;
    endfunction

    // One-cycle write; model follows the in-range rule of R8
    task automatic wr(int b, int c, logic [7:0] d);
        wb = 3'(b);
        wc = 7'(c);
        wd = d;
        we = 1'b1;
        if (b < 5 && c < COLS) mdl[b][c] = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wait_row_start(int r);
        int prev;
        bit found;
        prev = row_idx(rs);
        found = 1'b0;
        for (int i = 0; i < 8000 && !found; i++) begin
            @(negedge clk);
            if (row_idx(rs) == r && prev != r) found = 1'b1;
            prev = row_idx(rs);
        end
        check(found, "R2 row start reached", 128'(rs), 128'(onehot(r)));
    endtask

    task automatic t_reset();
        @(negedge clk);
        for (int b = 0; b < 5; b++) begin
            for (int c = 0; c < COLS; c++) wr(b, c, pat(b, c));
        end
        check(rs == '0 && co == '0 && pol == 1'b0, "R1 outputs low in reset",
              128'(rs), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(rs == '0 && co == '0, "R1 low after first start-up edge",
              128'(rs) | 128'(co), 128'(0));
        @(negedge clk);
        check(rs == onehot(0), "R1 row 0 after start-up", 128'(rs), 128'(onehot(0)));
        check(co == exp_line(0, 1'b0), "R6 row 0 columns", 128'(co),
              128'(exp_line(0, 1'b0)));
    endtask

    // Walk one frame from the first cycle of row 0 to the next row 0
    task automatic t_frame(logic pol_in);
        int cur;
        int len;
        int total;
        bit done;
        logic pe;
        cur = 0;
        len = 1;
        total = 1;
        done = 1'b0;
        pe = pol_in;
        for (int i = 0; i < 4000 && !done; i++) begin
            @(negedge clk);
            if (rs == onehot(cur)) begin
                len++;
                total++;
            end else begin
                int nxt;
                check(len == ((cur < 32) ? 77 : 76), "R3 row length",
                      128'(len), 128'((cur < 32) ? 77 : 76));
                nxt = (cur + 1) % ROWS;
                check(rs == onehot(nxt), "R2 next row", 128'(rs), 128'(onehot(nxt)));
                if (nxt == 0) begin
                    pe = ~pe;
                    check(total == FRAME, "R3 frame length", 128'(total), 128'(FRAME));
                    done = 1'b1;
                end
                check(pol == pe, "R4 polarity", 128'(pol), 128'(pe));
                check(co == exp_line(nxt, pe), "R6 row columns with polarity",
                      128'(co), 128'(exp_line(nxt, pe)));
                cur = nxt;
                len = 1;
                total++;
            end
        end
        check(done, "R2 frame completed", 128'(cur), 128'(0));
    endtask

    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            {me, md} = 2'(m);
            @(negedge clk);
            check(co == exp_line(row_idx(rs), pol), "R5 display mode",
                  128'(co), 128'(exp_line(row_idx(rs), pol)));
        end
        me = 1'b1;
        md = 1'b0;
    endtask

    task automatic t_latch();
        logic [COLS-1:0] old;
        repeat (4) @(negedge clk);
        old = co;
        wr(0, 3, mdl[0][3] ^ 8'h01);
        check(rs == onehot(0) && co == old, "R7 write hidden during row",
              128'(co), 128'(old));
        wait_row_start(0);
        check(co == exp_line(0, pol) && co[3] != (old[3] ^ pol ^ ~pol),
              "R7 write shown on next scan", 128'(co), 128'(exp_line(0, pol)));
    endtask

    task automatic t_oob();
        wr(0, 101, 8'hFF);
        wr(0, 127, 8'h00);
        wr(5, 0, 8'hAA);
        wr(7, 100, 8'h55);
        wait_row_start(1);
        check(co == exp_line(1, pol), "R8 out-of-range write ignored bank 0",
              128'(co), 128'(exp_line(1, pol)));
        wait_row_start(39);
        check(co == exp_line(39, pol), "R8 out-of-range write ignored bank 4",
              128'(co), 128'(exp_line(39, pol)));
    endtask

    task automatic t_pd();
        logic p0;
        int n;
        wait_row_start(5);
        repeat (10) @(negedge clk);
        p0 = pol;
        pd = 1'b1;
        @(negedge clk);
        check(&rs && &co, "R9 outputs forced high", 128'(rs), 128'(onehot(0) | ~onehot(0)));
        wr(0, 0, mdl[0][0] ^ 8'h40);
        repeat (20) @(negedge clk);
        check(pol == p0, "R9 polarity held", 128'(pol), 128'(p0));
        pd = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            if (rs == onehot(5)) n++;
        end while (rs == onehot(5) && n < 200);
        check(n == 66, "R9 remaining cycles of row 5", 128'(n), 128'(66));
        check(rs == onehot(6), "R9 scan continues", 128'(rs), 128'(onehot(6)));
        check(co == exp_line(6, pol), "R9 write during power-down kept",
              128'(co), 128'(exp_line(6, pol)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_frame(1'b0);
        t_frame(1'b1);
        t_modes();
        t_latch();
        t_oob();
        t_pd();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule